// File: doc/BRIEF.md
# Light-Load Burst Pulse Sequencer

This block runs a power converter in burst operation at light load. Each burst is a short train of gate pulses with a fixed on-time and a fixed spacing. After the train the block signals sleep until the next burst is due. The on-time and the pulse count come from an external feedback mapper. The switching period and the burst interval come from configuration. All four values are captured together at the last pulse of a burst and used for the burst that follows. The mapper can therefore change its outputs freely without disturbing a train that is already running.

A serial status reporter can share the sleep window. When reporting is enabled and the reporter says it is busy, the block holds off sleep at the end of a burst. It can also hold back the next burst until the transfer is done. When reporting is disabled, the busy flag is ignored and bursts follow the nominal interval exactly.

Top module: `burst_pulse_seq`

## Requirements
- R1: On-time, pulse count, switching period and burst interval are captured only on the clock edge that ends the last pulse of a burst, and they govern the next burst. Input changes at any other time have no effect on the burst that follows.
- R2: Each burst emits exactly the captured pulse count. A captured count of 0 yields one pulse. The pulse index restarts at every burst.
- R3: Every pulse holds `gateOut` high for exactly the captured on-time in clocks. An on-time of 0 is treated as 1.
- R4: Within a burst, consecutive pulse starts are spaced by the captured switching period. If the period is not larger than the effective on-time, the spacing is on-time + 1.
- R5: With no pending report, consecutive burst starts are exactly the captured burst interval apart in clocks.
- R6: `sleepOut` rises in the clock right after the last pulse ends and stays high until the clock in which the next burst starts. `gateOut` and `sleepOut` are never high together.
- R7: `lastPulseOut` is high for exactly one clock per burst: the final clock of the last pulse. The gate is low in the clock that follows.
- R8: If `reportEnIn` and `reportBusyIn` are both high in the final clock of the last pulse, sleep is withheld. `sleepOut` rises in the clock after the first clock in which busy is low. If that happens before the interval expires, the next burst still starts on the nominal schedule.
- R9: If `reportEnIn` and `reportBusyIn` are both high when the interval expires, `sleepOut` drops and the burst is postponed. The burst starts in the clock after the first clock with busy low.
- R10: With `reportEnIn` low, `reportBusyIn` has no effect on sleep or on burst timing.
- R11: While `rstN` is low, all three outputs are low. The first pulse starts in the clock after reset is released, using the inputs present in that first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| burstIntervalIn | input | IV_W (16) | Clocks between burst starts |
| onTimeIn | input | TON_W (8) | Mapped pulse on-time in clocks |
| pulseCountIn | input | CNT_W (6) | Mapped pulses per burst |
| swPeriodIn | input | PER_W (10) | Clocks between pulse starts inside a burst |
| reportEnIn | input | 1 | Serial reporting enable |
| reportBusyIn | input | 1 | Serial transfer in progress |
| gateOut | output | 1 | Power switch gate drive |
| sleepOut | output | 1 | Sleep indication between bursts |
| lastPulseOut | output | 1 | Strobe in the final clock of each burst |

## Verification
Some properties are checked in every clock:
- gate and sleep are mutually exclusive;
- the last-pulse strobe falls inside a pulse and is followed by a low gate;
- sleep is never entered in a clock after an enabled busy report;
- the waiting state is never reached with reporting disabled;
- a burst only leaves sleep once the interval counter reports it is due.

The bench scenarios measure what a single-cycle property cannot reach:
- the exact on-time, pulse count, spacing, sleep onset and burst interval for several parameter sets;
- that input changes between capture points are ignored;
- the cycle-exact delay caused by a busy report at both hold-off points, compared against the same stimulus with reporting disabled.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PULSE_ON  = 3'd1,
    ST_PULSE_OFF = 3'd2,
    ST_SLEEP     = 3'd3,
    ST_WAIT_TX   = 3'd4
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic latchParams;
    logic burstStart;
    logic phaseStart;
    logic pulseDone;
  } seqStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic onDone;
    logic offDone;
    logic lastOfBurst;
    logic ivDue;
  } seqStatus_t;

endpackage

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int TON_W = 8,
  parameter int CNT_W = 6,
  parameter int PER_W = 10,
  parameter int IV_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IV_W-1:0]  burstIntervalIn,
  input  logic [TON_W-1:0] onTimeIn,
  input  logic [CNT_W-1:0] pulseCountIn,
  input  logic [PER_W-1:0] swPeriodIn,
  input  seqStrobe_t       strb,
  output seqStatus_t       stat
);

  localparam int PH_W = ((TON_W > PER_W) ? TON_W : PER_W) + 1;
  localparam logic [PH_W-1:0] PH_MAX = '1;
  localparam logic [IV_W-1:0] IV_MAX = '1;

  logic [TON_W-1:0] tonLat;
  logic [CNT_W-1:0] cntLat;
  logic [PER_W-1:0] perLat;
  logic [IV_W-1:0]  ivLat;

  logic [PH_W-1:0]  phCnt;
  logic [CNT_W-1:0] pulseIdx;
  logic [IV_W-1:0]  ivCnt;

  logic [PH_W-1:0]  tonEff;
  logic [PH_W-1:0]  perExt;
  logic [PH_W-1:0]  offEff;
  logic [CNT_W-1:0] cntEff;
  logic [IV_W-1:0]  ivLast;

  // parameter capture at the end of a burst
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tonLat <= '0;
      cntLat <= '0;
      perLat <= '0;
      ivLat  <= '0;
    end else if (strb.latchParams) begin
      tonLat <= onTimeIn;
      cntLat <= pulseCountIn;
      perLat <= swPeriodIn;
      ivLat  <= burstIntervalIn;
    end
  end

  // effective values with zero clamping
  always_comb begin
    tonEff = (tonLat == '0) ? PH_W'(1) : PH_W'(tonLat);
    perExt = PH_W'(perLat);
    offEff = (perExt > tonEff) ? (perExt - tonEff) : PH_W'(1);
    cntEff = (cntLat == '0) ? CNT_W'(1) : cntLat;
    ivLast = (ivLat == '0) ? '0 : (ivLat - IV_W'(1));
  end

  // phase counter: clocks within the current on or off phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phCnt <= '0;
    end else if (strb.phaseStart) begin
      phCnt <= '0;
    end else if (phCnt != PH_MAX) begin
      phCnt <= phCnt + PH_W'(1);
    end
  end

  // pulse index within the burst
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseIdx <= '0;
    end else if (strb.burstStart) begin
      pulseIdx <= '0;
    end else if (strb.pulseDone) begin
      pulseIdx <= pulseIdx + CNT_W'(1);
    end
  end

  // clocks since the current burst started, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ivCnt <= '0;
    end else if (strb.burstStart) begin
      ivCnt <= '0;
    end else if (ivCnt != IV_MAX) begin
      ivCnt <= ivCnt + IV_W'(1);
    end
  end

  always_comb begin
    stat.onDone      = (phCnt == (tonEff - PH_W'(1)));
    stat.offDone     = (phCnt == (offEff - PH_W'(1)));
    stat.lastOfBurst = (pulseIdx == (cntEff - CNT_W'(1)));
    stat.ivDue       = (ivCnt >= ivLast);
  end

  // R2: a pulse is never advanced past the final one of the burst
  a_r2_no_pulse_overrun: assert property (@(posedge clk) disable iff (!rstN)
    strb.pulseDone |-> !stat.lastOfBurst);

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reportEnIn,
  input  logic       reportBusyIn,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       gateOut,
  output logic       sleepOut,
  output logic       lastPulseOut
);

  seqState_t stateQ, stateD;
  logic      txHold;

  assign txHold = reportEnIn & reportBusyIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        strb.latchParams = 1'b1;
        strb.burstStart  = 1'b1;
        strb.phaseStart  = 1'b1;
        stateD           = ST_PULSE_ON;
      end
      ST_PULSE_ON: begin
        if (stat.onDone) begin
          strb.phaseStart = 1'b1;
          if (stat.lastOfBurst) begin
            strb.latchParams = 1'b1;
            stateD           = txHold ? ST_WAIT_TX : ST_SLEEP;
          end else begin
            strb.pulseDone = 1'b1;
            stateD         = ST_PULSE_OFF;
          end
        end
      end
      ST_PULSE_OFF: begin
        if (stat.offDone) begin
          strb.phaseStart = 1'b1;
          stateD          = ST_PULSE_ON;
        end
      end
      ST_SLEEP: begin
        if (stat.ivDue) begin
          if (txHold) begin
            stateD = ST_WAIT_TX;
          end else begin
            strb.burstStart = 1'b1;
            strb.phaseStart = 1'b1;
            stateD          = ST_PULSE_ON;
          end
        end
      end
      ST_WAIT_TX: begin
        if (!txHold) begin
          if (stat.ivDue) begin
            strb.burstStart = 1'b1;
            strb.phaseStart = 1'b1;
            stateD          = ST_PULSE_ON;
          end else begin
            stateD = ST_SLEEP;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign gateOut      = (stateQ == ST_PULSE_ON);
  assign sleepOut     = (stateQ == ST_SLEEP);
  assign lastPulseOut = (stateQ == ST_PULSE_ON) && stat.onDone && stat.lastOfBurst;

  // R6: gate drive and sleep never overlap
  a_r6_gate_sleep_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(gateOut && sleepOut));

  // R7: strobe lies in the closing clock of a pulse
  a_r7_last_in_pulse: assert property (@(posedge clk) disable iff (!rstN)
    lastPulseOut |-> (gateOut && stat.onDone));

  // R7: gate is low right after the final pulse
  a_r7_last_then_low: assert property (@(posedge clk) disable iff (!rstN)
    lastPulseOut |=> !gateOut);

  // R8: sleep is never entered while an enabled report was busy
  a_r8_sleep_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepOut) |-> !($past(reportEnIn) && $past(reportBusyIn)));

  // R10: waiting on the reporter requires reporting enabled
  a_r10_wait_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT_TX) |-> $past(reportEnIn));

  // R5: leaving sleep for a burst only once the interval is due
  a_r5_start_when_due: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && $past(sleepOut)) |-> $past(stat.ivDue));

endmodule

// File: rtl/burst_pulse_seq.sv
module burst_pulse_seq
  import burst_seq_pkg::*;
#(
  parameter int TON_W = 8,
  parameter int CNT_W = 6,
  parameter int PER_W = 10,
  parameter int IV_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IV_W-1:0]  burstIntervalIn,
  input  logic [TON_W-1:0] onTimeIn,
  input  logic [CNT_W-1:0] pulseCountIn,
  input  logic [PER_W-1:0] swPeriodIn,
  input  logic             reportEnIn,
  input  logic             reportBusyIn,
  output logic             gateOut,
  output logic             sleepOut,
  output logic             lastPulseOut
);

  seqStrobe_t strb;
  seqStatus_t stat;

  burst_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reportEnIn   (reportEnIn),
    .reportBusyIn (reportBusyIn),
    .stat         (stat),
    .strb         (strb),
    .gateOut      (gateOut),
    .sleepOut     (sleepOut),
    .lastPulseOut (lastPulseOut)
  );

  burst_seq_dp #(
    .TON_W (TON_W),
    .CNT_W (CNT_W),
    .PER_W (PER_W),
    .IV_W  (IV_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .burstIntervalIn (burstIntervalIn),
    .onTimeIn        (onTimeIn),
    .pulseCountIn    (pulseCountIn),
    .swPeriodIn      (swPeriodIn),
    .strb            (strb),
    .stat            (stat)
  );

endmodule

// File: tb/tb_burst_pulse_seq.sv
`timescale 1ns/1ps
module tb_burst_pulse_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ivIn = 16'd60;
  logic [7:0]  tonIn = 8'd4;
  logic [5:0]  cntIn = 6'd3;
  logic [9:0]  perIn = 10'd8;
  logic        repEn = 1'b0;
  logic        busy = 1'b0;
  logic        gate, slp, lastP;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  burst_pulse_seq dut (
    .clk(clk), .rstN(rstN), .burstIntervalIn(ivIn), .onTimeIn(tonIn),
    .pulseCountIn(cntIn), .swPeriodIn(perIn), .reportEnIn(repEn),
    .reportBusyIn(busy), .gateOut(gate), .sleepOut(slp), .lastPulseOut(lastP)
  );

  // {on-time, count, period, interval}
  localparam int NV = 6;
  localparam int VT [NV][4] = '{
    '{3, 4, 10, 80}, '{5, 1, 8, 40}, '{0, 2, 6, 30},
    '{4, 0, 9, 25},  '{6, 3, 6, 60}, '{2, 8, 5, 100}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    summary();
  end

  task automatic waitRise();
    logic g0;
    g0 = gate;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (gate && !g0) return;
      g0 = gate;
    end
  endtask

  // called at the negedge of a burst's first clock; returns at the next burst start
  task automatic burstStats(input int chgK, input int chgTon,
                            output int np, output int onw, output int gap1,
                            output int span, output int slpAt, output int slpLen,
                            output int lastCnt);
    logic g0, seenLow, seenSleep;
    np = 1; onw = 0; gap1 = 0; span = 0; slpAt = -1; slpLen = 0; lastCnt = 0;
    g0 = 1'b0; seenLow = 1'b0; seenSleep = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      if (k > 0) @(negedge clk);
      if (k == chgK) tonIn = 8'(chgTon);
      if (gate && !g0 && k > 0) begin
        if (seenSleep) begin span = k; return; end
        np++;
        if (np == 2) gap1 = k;
      end
      if (gate && !seenLow) onw++;
      if (!gate) seenLow = 1'b1;
      if (lastP) lastCnt++;
      if (slp) begin
        if (!seenSleep) slpAt = k;
        seenSleep = 1'b1;
        slpLen++;
      end
      g0 = gate;
    end
  endtask

  task automatic checkBurst(input int ton, input int cnt, input int per, input int iv,
                            input int np, input int onw, input int gap1, input int span,
                            input int slpAt, input int slpLen, input int lastCnt);
    int tE, nE, offE, pE;
    tE = (ton == 0) ? 1 : ton;
    nE = (cnt == 0) ? 1 : cnt;
    offE = (per > tE) ? per - tE : 1;
    pE = tE + offE;
    chk("R2 pulse count", np, nE);
    chk("R3 on-time", onw, tE);
    if (nE > 1) chk("R4 pulse spacing", gap1, pE);
    chk("R5 burst interval", span, iv);
    chk("R6 sleep onset", slpAt, (nE - 1) * pE + tE);
    chk("R6 sleep length", slpLen, iv - ((nE - 1) * pE + tE));
    chk("R7 strobe count", lastCnt, 1);
  endtask

  task automatic busyRun(input logic en, output int rise, output int s14, output int s16,
                         output int s18, output int s45, output int s55);
    rise = -1; s14 = -1; s16 = -1; s18 = -1; s45 = -1; s55 = -1;
    repEn = en;
    for (int k = 0; k < 200; k++) begin
      if (k > 0) @(negedge clk);
      if (k > 0 && gate && rise < 0 && k > 20) rise = k;
      if (k == 14) s14 = int'(slp);
      if (k == 16) s16 = int'(slp);
      if (k == 18) s18 = int'(slp);
      if (k == 45) s45 = int'(slp);
      if (k == 55) s55 = int'(slp);
      busy = ((k >= 5 && k <= 15) || (k >= 40 && k <= 69));
      if (rise >= 0) begin busy = 1'b0; repEn = 1'b0; return; end
    end
  endtask

  initial begin
    int np, onw, gap1, span, slpAt, slpLen, lastCnt;
    int rise, s14, s16, s18, s45, s55;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 gate in reset", int'(gate), 0);
    chk("R11 sleep in reset", int'(slp), 0);
    chk("R11 strobe in reset", int'(lastP), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 first pulse after release", int'(gate), 1);
    burstStats(-1, 0, np, onw, gap1, span, slpAt, slpLen, lastCnt);
    checkBurst(4, 3, 8, 60, np, onw, gap1, span, slpAt, slpLen, lastCnt);

    // table walk: new inputs at a burst start are used by the following burst
    for (int v = 0; v < NV; v++) begin
      tonIn = 8'(VT[v][0]); cntIn = 6'(VT[v][1]);
      perIn = 10'(VT[v][2]); ivIn = 16'(VT[v][3]);
      burstStats(-1, 0, np, onw, gap1, span, slpAt, slpLen, lastCnt);
      burstStats(-1, 0, np, onw, gap1, span, slpAt, slpLen, lastCnt);
      checkBurst(VT[v][0], VT[v][1], VT[v][2], VT[v][3],
                 np, onw, gap1, span, slpAt, slpLen, lastCnt);
    end

    // R1: mid-burst and mid-sleep changes do not reach the wrong burst
    tonIn = 8'd3; cntIn = 6'd4; perIn = 10'd10; ivIn = 16'd80;
    burstStats(-1, 0, np, onw, gap1, span, slpAt, slpLen, lastCnt);
    tonIn = 8'd5; cntIn = 6'd2;
    burstStats(40, 7, np, onw, gap1, span, slpAt, slpLen, lastCnt);
    chk("R1 running burst count kept", np, 4);
    chk("R1 running burst on-time kept", onw, 3);
    burstStats(-1, 0, np, onw, gap1, span, slpAt, slpLen, lastCnt);
    chk("R1 count captured at last pulse", np, 2);
    chk("R1 sleep-time change ignored", onw, 5);

    // R8/R9: busy report holds off sleep and the next burst
    tonIn = 8'd3; cntIn = 6'd2; perIn = 10'd10; ivIn = 16'd50;
    burstStats(-1, 0, np, onw, gap1, span, slpAt, slpLen, lastCnt);
    burstStats(-1, 0, np, onw, gap1, span, slpAt, slpLen, lastCnt);
    busyRun(1'b1, rise, s14, s16, s18, s45, s55);
    chk("R8 sleep withheld while busy", s14, 0);
    chk("R8 sleep withheld busy last clock", s16, 0);
    chk("R8 sleep after busy clears", s18, 1);
    chk("R9 sleep kept before due", s45, 1);
    chk("R9 sleep dropped while waiting", s55, 0);
    chk("R9 postponed burst start", rise, 71);

    // R10: same busy pattern with reporting disabled
    busyRun(1'b0, rise, s14, s16, s18, s45, s55);
    chk("R10 sleep despite busy", s14, 1);
    chk("R10 sleep held past due busy", s45, 1);
    chk("R10 nominal start", rise, 50);

    // R11: reset in mid-pulse clears gate
    waitRise();
    @(posedge clk); #1;
    rstN = 1'b0; #1;
    chk("R11 gate cleared by reset", int'(gate), 0);
    chk("R11 sleep cleared by reset", int'(slp), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 restart after release", int'(gate), 1);

    summary();
  end

endmodule